// File: doc/BRIEF.md
# Non-cacheable region address decoder

This block decides whether a 32-bit physical address must bypass the cache. Software sets it up through an 8-bit port interface. A port index, a write byte and a write strobe store a byte on the next rising clock edge. The read byte always reflects the register at the current port index, with no added delay. A lookup address goes in and one non-cacheable flag comes out, with no clock between them.

Two fixed legacy windows can be switched on by bits of a control byte. The first covers the lowest 64 KB of every 1 MB block. The second covers the range from 640 KB to 1 MB. There are also programmable regions, each three bytes wide. Each region holds a base address and a four-bit size code. The size runs from 4 KB upward, doubling with each step, and the largest code covers the whole 4 GB space. The flag is the OR of every window and region that matches. A region uses whichever bytes are stored at that moment, so each byte write takes effect at once.

Top module: `ncr_decoder`

## Requirements
- R1: After reset every register reads 0x00 and `nonCacheable` is 0 for any address.
- R2: Port 0xC0 is control byte A and stores all 8 bits. Port 0xC1 is control byte B: bit 0 is stored, and bits 7:1 always read back as zero. A read returns the byte stored at the current port index in the same cycle.
- R3: Region k (k = 0..3) uses ports 0xC4+3k, 0xC5+3k and 0xC6+3k. The first port holds base bits 31:24 and the second holds bits 23:16. The third holds base bits 15:12 in bits 7:4 and the size code in bits 3:0. Each byte is written separately.
- R4: With control byte A bit 0 set, an address is non-cacheable when its bits 19:16 are all zero, in every 1 MB block.
- R5: With control byte A bit 1 set, addresses 0x000A0000 through 0x000FFFFF are non-cacheable, and no other address is matched by this window.
- R6: Size code 0 disables its region. Codes 1 to 14 give a region of 2^(code+11) bytes, from 4 KB up to 32 MB.
- R7: Size code 15 makes every address non-cacheable while it is stored.
- R8: Only the address bits at or above the region size are compared. A misaligned base therefore acts as if it were rounded down to the size.
- R9: `nonCacheable` is the OR of both legacy windows and all region matches. It follows `lookupAddr` and the stored bytes combinationally.
- R10: Writes to unmapped port indices change no stored byte and no lookup result, and reads of unmapped indices return 0x00.
- R11: A region with partly written bytes takes effect right after each byte write, with no staging of the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portIdx | input | 8 | Port index for read and write |
| wrData | input | 8 | Byte to store |
| wrEn | input | 1 | Write strobe, sampled on rising edge |
| rdData | output | 8 | Byte stored at portIdx |
| lookupAddr | input | 32 | Physical address to classify |
| nonCacheable | output | 1 | High when lookupAddr must bypass the cache |

## Verification
The bench builds the block with its default four regions, placed at port 0xC4 and above, so every region port from 0xC4 to 0xCF and both control ports can be exercised. Directed cases probe the first and last address of each window. They also cover the 4 KB and 32 MB size codes, the full-space code, a misaligned base, and a region caught halfway through being written. Random writes over 0xC0 to 0xCF and outside that range, mixed with random lookups, then exercise the OR across overlapping regions.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
  // Decoded port selection; one instance carries write strobes, one read select.
  typedef struct packed {
    logic       cfgA;
    logic       cfgB;
    logic       region;
    logic [2:0] regIdx;   // up to eight regions
    logic [1:0] regByte;  // 0..2 within a region
  } portSel_t;

  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SIZE_SHIFT = 11;  // size = 2^(code+SIZE_SHIFT)
  localparam int unsigned MB_BITS    = 20;
  localparam int unsigned LOWWIN_BITS = 16;
endpackage

// File: rtl/ncr_ctrl.sv
module ncr_ctrl
  import ncr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS   = 4,
  parameter logic [7:0]  CFGA_IDX      = 8'hC0,
  parameter logic [7:0]  CFGB_IDX      = 8'hC1,
  parameter logic [7:0]  REGION_BASE   = 8'hC4
) (
  input  logic [7:0] portIdx,
  input  logic       wrEn,
  output portSel_t   rdSel,
  output portSel_t   wrStb
);
  always_comb begin
    rdSel = '0;
    rdSel.cfgA = (portIdx == CFGA_IDX);
    rdSel.cfgB = (portIdx == CFGB_IDX);
    for (int i = 0; i < NUM_REGIONS; i++) begin
      for (int j = 0; j < 3; j++) begin
        if (portIdx == 8'(int'(REGION_BASE) + 3 * i + j)) begin
          rdSel.region  = 1'b1;
          rdSel.regIdx  = 3'(i);
          rdSel.regByte = 2'(j);
        end
      end
    end
  end

  always_comb begin
    wrStb        = rdSel;
    wrStb.cfgA   = rdSel.cfgA & wrEn;
    wrStb.cfgB   = rdSel.cfgB & wrEn;
    wrStb.region = rdSel.region & wrEn;
  end
endmodule

// File: rtl/ncr_datapath.sv
module ncr_datapath
  import ncr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  portSel_t          wrStb,
  input  portSel_t          rdSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              nonCacheable
);
  logic [BYTE_W-1:0] cfgAQ;
  logic              cfgBQ;
  logic [BYTE_W-1:0] regQ [NUM_REGIONS][3];
  logic [NUM_REGIONS-1:0] regionHit;
  logic lowWinHit, vgaWinHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAQ <= '0;
      cfgBQ <= 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++)
        for (int j = 0; j < 3; j++)
          regQ[i][j] <= '0;
    end else begin
      if (wrStb.cfgA) cfgAQ <= wrData;
      if (wrStb.cfgB) cfgBQ <= wrData[0];
      for (int i = 0; i < NUM_REGIONS; i++)
        for (int j = 0; j < 3; j++)
          if (wrStb.region && wrStb.regIdx == 3'(i) && wrStb.regByte == 2'(j))
            regQ[i][j] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel.cfgA) rdData = cfgAQ;
    if (rdSel.cfgB) rdData = {7'b0, cfgBQ};
    for (int i = 0; i < NUM_REGIONS; i++)
      for (int j = 0; j < 3; j++)
        if (rdSel.region && rdSel.regIdx == 3'(i) && rdSel.regByte == 2'(j))
          rdData = regQ[i][j];
  end

  // Fixed legacy windows
  assign lowWinHit = cfgAQ[0] & (lookupAddr[MB_BITS-1:LOWWIN_BITS] == '0);
  assign vgaWinHit = cfgAQ[1] & (lookupAddr[ADDR_W-1:MB_BITS] == '0)
                   & (lookupAddr[MB_BITS-1:17] >= 3'b101);

  // Programmable regions
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [ADDR_W-1:0] baseAddr;
    logic [ADDR_W-1:0] keepMask;
    logic [3:0]        sizeCode;
    assign sizeCode = regQ[g][2][3:0];
    assign baseAddr = {regQ[g][0], regQ[g][1], regQ[g][2][7:4], 12'h000};
    assign keepMask = {ADDR_W{1'b1}} << (5'(sizeCode) + 5'(SIZE_SHIFT));
    assign regionHit[g] = (sizeCode == 4'hF) |
                          ((sizeCode != 4'h0) &
                           (((lookupAddr ^ baseAddr) & keepMask) == '0));
  end

  assign nonCacheable = lowWinHit | vgaWinHit | (|regionHit);
endmodule

// File: rtl/ncr_decoder.sv
module ncr_decoder
  import ncr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter logic [7:0]  CFGA_IDX    = 8'hC0,
  parameter logic [7:0]  CFGB_IDX    = 8'hC1,
  parameter logic [7:0]  REGION_BASE = 8'hC4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  portIdx,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  output logic [7:0]  rdData,
  input  logic [31:0] lookupAddr,
  output logic        nonCacheable
);
  portSel_t rdSel, wrStb;

  ncr_ctrl #(
    .NUM_REGIONS(NUM_REGIONS), .CFGA_IDX(CFGA_IDX),
    .CFGB_IDX(CFGB_IDX), .REGION_BASE(REGION_BASE)
  ) u_ctrl (
    .portIdx(portIdx), .wrEn(wrEn), .rdSel(rdSel), .wrStb(wrStb)
  );

  ncr_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdSel(rdSel),
    .wrData(wrData), .lookupAddr(lookupAddr),
    .rdData(rdData), .nonCacheable(nonCacheable)
  );
endmodule

// File: rtl/ncr_decoder_chk.sv
module ncr_decoder_chk #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter logic [7:0]  CFGA_IDX    = 8'hC0,
  parameter logic [7:0]  CFGB_IDX    = 8'hC1,
  parameter logic [7:0]  REGION_BASE = 8'hC4
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  portIdx,
  input logic [7:0]  wrData,
  input logic        wrEn,
  input logic [7:0]  rdData,
  input logic [31:0] lookupAddr,
  input logic        nonCacheable
);
  logic unmapped;
  assign unmapped = (portIdx != CFGA_IDX) && (portIdx != CFGB_IDX) &&
                    ((portIdx < REGION_BASE) ||
                     (int'(portIdx) >= int'(REGION_BASE) + 3 * int'(NUM_REGIONS)));

  assert_cfgb_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (portIdx == CFGB_IDX) |-> (rdData[7:1] == 7'b0));

  assert_cfga_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx == CFGA_IDX) |=> (portIdx != CFGA_IDX || rdData == $past(wrData)));

  assert_vga_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (portIdx == CFGA_IDX && rdData[1] &&
     lookupAddr >= 32'h000A_0000 && lookupAddr <= 32'h000F_FFFF) |-> nonCacheable);

  assert_low_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (portIdx == CFGA_IDX && rdData[0] && lookupAddr[19:16] == 4'h0) |-> nonCacheable);

  assert_full_space_R7: assert property (@(posedge clk) disable iff (!rstN)
    (portIdx == REGION_BASE + 8'd2 && rdData[3:0] == 4'hF) |-> nonCacheable);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && unmapped) |=> ($stable(lookupAddr) -> $stable(nonCacheable)));

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> (rdData == 8'h00));
endmodule

bind ncr_decoder ncr_decoder_chk #(
  .NUM_REGIONS(NUM_REGIONS), .CFGA_IDX(CFGA_IDX),
  .CFGB_IDX(CFGB_IDX), .REGION_BASE(REGION_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .portIdx(portIdx), .wrData(wrData), .wrEn(wrEn),
  .rdData(rdData), .lookupAddr(lookupAddr), .nonCacheable(nonCacheable)
);

// File: tb/ncr_decoder_bench.sv
module ncr_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  portIdx = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic        wrEn = 1'b0;
  logic [7:0]  rdData;
  logic [31:0] lookupAddr = 32'h0;
  logic        nonCacheable;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Shadow of the programming, maintained from the requirements
  logic [7:0] mA;
  logic       mB;
  logic [7:0] mReg [4][3];

  always #5 clk = ~clk;

  ncr_decoder u_ncr_decoder (
    .clk(clk), .rstN(rstN), .portIdx(portIdx), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .lookupAddr(lookupAddr), .nonCacheable(nonCacheable)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] idx);
    if (idx == 8'hC0) return mA;
    if (idx == 8'hC1) return {7'b0, mB};
    if (idx >= 8'hC4 && idx <= 8'hCF) return mReg[(idx - 8'hC4) / 3][(idx - 8'hC4) % 3];
    return 8'h00;
  endfunction

  function automatic bit expNc(input logic [31:0] a);
    bit hit = 0;
    if (mA[0] && (a % 32'h10_0000) < 32'h1_0000) hit = 1;
    if (mA[1] && a >= 32'h000A_0000 && a <= 32'h000F_FFFF) hit = 1;
    for (int k = 0; k < 4; k++) begin
      longint unsigned sz, lo, base;
      int code = int'(mReg[k][2][3:0]);
      base = {mReg[k][0], mReg[k][1], mReg[k][2][7:4], 12'h000};
      if (code == 15) hit = 1;
      else if (code != 0) begin
        sz = 64'd1 << (code + 11);
        lo = base - (base % sz);
        if (longint'(a) >= lo && longint'(a) < lo + sz) hit = 1;
      end
    end
    return hit;
  endfunction

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    portIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx == 8'hC0) mA = d;
    else if (idx == 8'hC1) mB = d[0];
    else if (idx >= 8'hC4 && idx <= 8'hCF) mReg[(idx - 8'hC4) / 3][(idx - 8'hC4) % 3] = d;
  endtask

  task automatic look(input string req, input logic [31:0] a);
    lookupAddr = a;
    #1;
    chk(req, $sformatf("nc@%h", a), 32'(nonCacheable), 32'(expNc(a)));
  endtask

  task automatic rd(input string req, input logic [7:0] idx);
    portIdx = idx;
    #1;
    chk(req, $sformatf("rd@%h", idx), 32'(rdData), 32'(expRead(idx)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mA = '0; mB = 0;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 3; j++) mReg[k][j] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int p = 8'hC0; p <= 8'hCF; p++) rd("R1", 8'(p));
    look("R1", 32'h0000_0000);
    look("R1", 32'h000B_8000);
    look("R1", 32'hFFFF_F000);

    // R2: control byte B reserved bits, control byte A readback
    wr(8'hC1, 8'hFF); rd("R2", 8'hC1);
    chk("R2", "cfgB reserved", 32'(rdData), 32'h01);
    wr(8'hC0, 8'h00); rd("R2", 8'hC0);

    // R10: unmapped writes ignored
    wr(8'hC2, 8'hFF); wr(8'hC3, 8'hFF); wr(8'h10, 8'h03); wr(8'hD0, 8'h0F);
    rd("R10", 8'hC2); rd("R10", 8'hD0); rd("R10", 8'hC0);
    look("R10", 32'h000A_0000);
    chk("R10", "nc after unmapped", 32'(nonCacheable), 32'h0);

    // R4: low 64 KB of every MB
    wr(8'hC0, 8'h01);
    look("R4", 32'h0030_5000); look("R4", 32'h0031_0000);
    look("R4", 32'hFFF0_FFFF); look("R4", 32'h000A_0000);

    // R5: 640K..1M window
    wr(8'hC0, 8'h02);
    look("R5", 32'h0009_FFFF); look("R5", 32'h000A_0000);
    look("R5", 32'h000F_FFFF); look("R5", 32'h0010_0000);
    look("R5", 32'h010A_0000);
    wr(8'hC0, 8'h00);

    // R11 + R3: partial region update, then 4 KB region at 0x12345000
    wr(8'hC4, 8'h12); look("R11", 32'h1234_5000);
    wr(8'hC5, 8'h34); look("R11", 32'h1234_5000);
    wr(8'hC6, 8'h51);
    look("R3", 32'h1234_5000); look("R6", 32'h1234_5FFF);
    look("R6", 32'h1234_6000); look("R6", 32'h1234_4FFF);
    wr(8'hC4, 8'h55); look("R11", 32'h1234_5000); look("R11", 32'h5534_5000);

    // R6: 32 MB region at 0x02000000 (region 1)
    wr(8'hC7, 8'h02); wr(8'hC8, 8'h00); wr(8'hC9, 8'h0E);
    look("R6", 32'h0200_0000); look("R6", 32'h03FF_FFFF);
    look("R6", 32'h0400_0000); look("R6", 32'h01FF_FFFF);

    // R8: misaligned 64 KB region base 0x00123000 (region 2)
    wr(8'hCA, 8'h00); wr(8'hCB, 8'h12); wr(8'hCC, 8'h35);
    look("R8", 32'h0012_0000); look("R8", 32'h0012_FFFF);
    look("R8", 32'h0013_0000); look("R8", 32'h0011_FFFF);

    // R7: full-space code on region 3, then disable
    wr(8'hCD, 8'h00); wr(8'hCE, 8'h00); wr(8'hCF, 8'h0F);
    look("R7", 32'hDEAD_B000); look("R7", 32'h0000_0000);
    wr(8'hCF, 8'h00);
    look("R6", 32'hDEAD_B000);

    // R9: all sources combined, random lookups
    wr(8'hC0, 8'h03);
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      a = (n % 2 == 0) ? $urandom() : ($urandom() & 32'h03FF_FFFF);
      look("R9", a);
    end

    // Random programming mixed with lookups and reads
    for (int n = 0; n < 400; n++) begin
      logic [7:0] idx, d;
      idx = ($urandom() % 8 == 0) ? 8'($urandom()) : 8'(8'hC0 + $urandom() % 16);
      d = 8'($urandom());
      if (idx >= 8'hC4 && idx <= 8'hCF && (idx - 8'hC4) % 3 == 2)
        d[3:0] = 4'($urandom() % 15);
      wr(idx, d);
      rd("R2", idx);
      look("R9", $urandom());
      look("R9", $urandom() & 32'h00FF_FFFF);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule